// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of an eight-input interrupt controller. Each clock it samples eight request lines into a request register. A per-line trigger-mode vector selects, for each line, whether the request bit copies the line level or is set by a rising edge. From the request register, a programmable mask, the in-service register and a rotation offset, it works out combinationally whether a new interrupt should go to the processor, and which line wins.

Priority is circular. Rank 0 goes to line `rot_state`, rank 1 to the line after it, and so on, wrapping round modulo eight. A pending request wins only if its rank is strictly better than the best rank already in service. A special-mask option hides masked lines from the in-service comparison. A fully-nested option on a master instance hides the cascade line's in-service bit.

An acknowledge pulse accepts the current winner. In normal mode it marks the winner as in service. In auto-EOI mode it does not, and it can rotate the priority so that the accepted line becomes the lowest. A specific end-of-interrupt input clears one in-service bit. The mask and the offset are loaded through write strobes. The request, mask, in-service and offset registers are visible on ports so that an outer register interface can read them.

Top module: `irq_resolver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the request, mask, in-service, rotation-offset and previous-level registers, so that `irq_valid` is 0 afterwards. It does not change `trig_level`.
- R2: A line whose `trig_level` bit is 1 is level-sensed. Its request bit equals the line value sampled at the previous clock edge, so it clears when the line goes low, and an acknowledge never clears it.
- R3: A line whose `trig_level` bit is 0 is edge-sensed. Its request bit sets when the line is 1 at a clock edge after being 0 at the edge before. A low line does not clear the bit, and a line held high does not set it again after it has been cleared.
- R4: Pending requests are the request bits whose `mask_state` bit is 0 (mask bit 1 means blocked). A request that is only on a masked line never sets `irq_valid`.
- R5: Rank k belongs to line (k + `rot_state`) mod 8, and rank 0 is the highest. `irq_line` is the line of the best pending rank.
- R6: `irq_valid` is 1 only when the best pending rank is strictly better than the best in-service rank. An equal or worse pending rank gives 0.
- R7: When `spec_mask` is 1, in-service bits of masked lines are left out of the in-service rank.
- R8: In a master instance with `nested` = 1, the in-service bit of the cascade line (line 2) is left out of the in-service rank.
- R9: An `ack` while `irq_valid` = 1 and `auto_eoi` = 0 sets the winner's in-service bit. The winner's request bit is cleared only if that line is edge-sensed.
- R10: An `ack` while `irq_valid` = 1 and `auto_eoi` = 1 leaves the in-service register unchanged. If `rot_auto` is also 1, `rot_state` becomes (winner + 1) mod 8.
- R11: An `ack` while `irq_valid` = 0 changes no request, in-service or offset bit.
- R12: `eoi_valid` clears the in-service bit of line `eoi_line` at the next edge.
- R13: `mask_we` loads `mask_wdata` into the mask register, and `rot_we` loads `rot_wdata` into the offset. A `rot_we` takes precedence over an auto-EOI rotation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line sensing: 1 level, 0 rising edge |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value, 1 blocks a line |
| rot_we | input | 1 | Rotation offset write strobe |
| rot_wdata | input | 3 | New rotation offset (line of rank 0) |
| spec_mask | input | 1 | Special-mask option |
| nested | input | 1 | Fully-nested option (master only) |
| auto_eoi | input | 1 | Auto end-of-interrupt on acknowledge |
| rot_auto | input | 1 | Rotate on auto end-of-interrupt |
| ack | input | 1 | Acknowledge the current winner |
| eoi_valid | input | 1 | Clear one in-service bit |
| eoi_line | input | 3 | Line whose in-service bit is cleared |
| irq_valid | output | 1 | Interrupt should be raised |
| irq_line | output | 3 | Winning line number |
| req_state | output | 8 | Request register |
| mask_state | output | 8 | Mask register |
| serv_state | output | 8 | In-service register |
| rot_state | output | 3 | Rotation offset |

## Verification
A wrong request bit shows up on `req_state` one edge after the line change that caused it. Through the resolver it also shows as a wrong `irq_valid` or `irq_line` in the same cycle. A stale or missing in-service bit changes no output until a competing request arrives: it then lets through, or holds back, a request that should not have been, so the tests set up an in-service line first and then a pending one. A wrong offset shows as the wrong winner only when two or more lines are pending. For that reason the rotation is checked with requests on both sides of the offset.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  // Option flags gathered for the resolver and service logic.
  typedef struct packed {
    logic spec_mask;
    logic nested;
    logic auto_eoi;
    logic rot_auto;
  } irq_mode_t;

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] trig_level,
  input  logic [N_LINES-1:0] clr_bits,
  output logic [N_LINES-1:0] req_q
);

  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] req_next;

  assign rise = req_in & ~prev_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_comb begin
      if (trig_level[i]) begin
        req_next[i] = req_in[i];
      end else begin
        // a fresh edge wins over an acknowledge clear in the same cycle
        req_next[i] = (req_q[i] & ~clr_bits[i]) | rise[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      prev_q <= '0;
    end else begin
      req_q  <= req_next;
      prev_q <= req_in;
    end
  end

endmodule

// File: rtl/irq_scan.sv
module irq_scan #(
  parameter int N_LINES   = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2,
  localparam int IW = $clog2(N_LINES),
  localparam int RW = IW + 1
) (
  input  logic [N_LINES-1:0] req_q,
  input  logic [N_LINES-1:0] mask_q,
  input  logic [N_LINES-1:0] serv_q,
  input  logic [IW-1:0]      rot_q,
  input  irq_res_pkg::irq_mode_t mode,
  output logic               win_valid,
  output logic [IW-1:0]      win_line,
  output logic [RW-1:0]      pend_rank,
  output logic [RW-1:0]      serv_rank
);

  // best rank of a set under the rotation; N_LINES means empty
  function automatic logic [RW-1:0] rank_of(input logic [N_LINES-1:0] set,
                                            input logic [IW-1:0] off);
    logic [RW-1:0] r;
    r = RW'(N_LINES);
    for (int k = N_LINES - 1; k >= 0; k--) begin
      if (set[(k + int'(off)) % N_LINES]) r = RW'(k);
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] line_of(input logic [RW-1:0] rank,
                                            input logic [IW-1:0] off);
    return IW'((int'(rank) + int'(off)) % N_LINES);
  endfunction

  logic [N_LINES-1:0] pend_set;
  logic [N_LINES-1:0] serv_vis;
  logic [N_LINES-1:0] casc_hide;

  if (IS_MASTER) begin : g_master
    assign casc_hide = N_LINES'(1) << CASC_LINE;
  end else begin : g_slave
    assign casc_hide = '0;
  end

  assign pend_set = req_q & ~mask_q;

  always_comb begin
    serv_vis = serv_q;
    if (mode.spec_mask) serv_vis = serv_vis & ~mask_q;
    if (mode.nested)    serv_vis = serv_vis & ~casc_hide;
  end

  assign pend_rank = rank_of(pend_set, rot_q);
  assign serv_rank = rank_of(serv_vis, rot_q);
  assign win_valid = pend_rank < serv_rank;
  assign win_line  = line_of(pend_rank, rot_q);

endmodule

// File: rtl/irq_service.sv
module irq_service #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_fire,
  input  logic [IW-1:0]      ack_line,
  input  irq_res_pkg::irq_mode_t mode,
  input  logic               eoi_valid,
  input  logic [IW-1:0]      eoi_line,
  input  logic               rot_we,
  input  logic [IW-1:0]      rot_wdata,
  output logic [N_LINES-1:0] serv_q,
  output logic [IW-1:0]      rot_q
);

  function automatic logic [IW-1:0] after_line(input logic [IW-1:0] l);
    return IW'((int'(l) + 1) % N_LINES);
  endfunction

  logic [N_LINES-1:0] set_bits;
  logic [N_LINES-1:0] clr_bits;

  assign set_bits = (ack_fire && !mode.auto_eoi) ? (N_LINES'(1) << ack_line) : '0;
  assign clr_bits = eoi_valid ? (N_LINES'(1) << eoi_line) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      serv_q <= '0;
      rot_q  <= '0;
    end else begin
      serv_q <= (serv_q & ~clr_bits) | set_bits;
      if (rot_we) begin
        rot_q <= rot_wdata;
      end else if (ack_fire && mode.auto_eoi && mode.rot_auto) begin
        rot_q <= after_line(ack_line);
      end
    end
  end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N_LINES   = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2,
  localparam int IW = $clog2(N_LINES),
  localparam int RW = IW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] trig_level,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic               rot_we,
  input  logic [IW-1:0]      rot_wdata,
  input  logic               spec_mask,
  input  logic               nested,
  input  logic               auto_eoi,
  input  logic               rot_auto,
  input  logic               ack,
  input  logic               eoi_valid,
  input  logic [IW-1:0]      eoi_line,
  output logic               irq_valid,
  output logic [IW-1:0]      irq_line,
  output logic [N_LINES-1:0] req_state,
  output logic [N_LINES-1:0] mask_state,
  output logic [N_LINES-1:0] serv_state,
  output logic [IW-1:0]      rot_state
);

  irq_res_pkg::irq_mode_t mode;
  logic               ack_fire;
  logic [N_LINES-1:0] req_clr;
  logic [N_LINES-1:0] mask_q;
  logic [RW-1:0]      pend_rank;
  logic [RW-1:0]      serv_rank;

  assign mode = '{spec_mask: spec_mask, nested: nested,
                  auto_eoi: auto_eoi, rot_auto: rot_auto};

  // acknowledge accepted only when a winner exists
  assign ack_fire = ack & irq_valid;
  assign req_clr  = ack_fire ? ((N_LINES'(1) << irq_line) & ~trig_level) : '0;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  irq_capture #(.N_LINES(N_LINES)) u_cap (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
    .clr_bits(req_clr), .req_q(req_state)
  );

  irq_scan #(.N_LINES(N_LINES), .IS_MASTER(IS_MASTER), .CASC_LINE(CASC_LINE)) u_scan (
    .req_q(req_state), .mask_q(mask_q), .serv_q(serv_state), .rot_q(rot_state),
    .mode(mode), .win_valid(irq_valid), .win_line(irq_line),
    .pend_rank(pend_rank), .serv_rank(serv_rank)
  );

  irq_service #(.N_LINES(N_LINES)) u_svc (
    .clk(clk), .rst(rst), .ack_fire(ack_fire), .ack_line(irq_line), .mode(mode),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .rot_we(rot_we),
    .rot_wdata(rot_wdata), .serv_q(serv_state), .rot_q(rot_state)
  );

  assign mask_state = mask_q;

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES),
  localparam int RW = IW + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] req_in,
  input logic [N_LINES-1:0] trig_level,
  input logic               rot_we,
  input logic               mask_we,
  input logic               auto_eoi,
  input logic               rot_auto,
  input logic               ack,
  input logic               eoi_valid,
  input logic [IW-1:0]      eoi_line,
  input logic               irq_valid,
  input logic [IW-1:0]      irq_line,
  input logic [N_LINES-1:0] req_state,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] serv_state,
  input logic [IW-1:0]      rot_state,
  input logic [RW-1:0]      pend_rank,
  input logic [RW-1:0]      serv_rank
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (req_state == '0 && serv_state == '0 && rot_state == '0 && mask_q == '0));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((req_state ^ $past(req_in)) & $past(trig_level)) == '0));

  // R4
  winner_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (req_state[irq_line] && !mask_q[irq_line]));

  // R6
  strict_rank_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (serv_rank > pend_rank));

  // R9
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid && !auto_eoi && !eoi_valid) |=> serv_state[$past(irq_line)]);

  // R10
  aeoi_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid && auto_eoi && !eoi_valid) |=> serv_state == $past(serv_state));

  // R10
  aeoi_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid && auto_eoi && rot_auto && !rot_we)
      |=> rot_state == IW'($past(irq_line) + 1'b1));

  // R11
  spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !irq_valid && !eoi_valid && !rot_we) |=> $stable(serv_state) && $stable(rot_state));

  // R12
  eoi_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !(ack && irq_valid && !auto_eoi)) |=> !serv_state[$past(eoi_line)]);

  // R13
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q));

endmodule

bind irq_resolver irq_resolver_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
  .rot_we(rot_we), .mask_we(mask_we), .auto_eoi(auto_eoi), .rot_auto(rot_auto),
  .ack(ack), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
  .irq_valid(irq_valid), .irq_line(irq_line), .req_state(req_state),
  .mask_q(mask_q), .serv_state(serv_state), .rot_state(rot_state),
  .pend_rank(pend_rank), .serv_rank(serv_rank)
);

// File: tb/irq_resolver_test.sv
`timescale 1ns/1ps
module irq_resolver_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_in;
  logic [7:0] trig_level;
  logic       mask_we;
  logic [7:0] mask_wdata;
  logic       rot_we;
  logic [2:0] rot_wdata;
  logic       spec_mask, nested, auto_eoi, rot_auto;
  logic       ack, eoi_valid;
  logic [2:0] eoi_line;
  logic       irq_valid;
  logic [2:0] irq_line;
  logic [7:0] req_state, mask_state, serv_state;
  logic [2:0] rot_state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_resolver uut (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .rot_we(rot_we),
    .rot_wdata(rot_wdata), .spec_mask(spec_mask), .nested(nested),
    .auto_eoi(auto_eoi), .rot_auto(rot_auto), .ack(ack),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .irq_valid(irq_valid),
    .irq_line(irq_line), .req_state(req_state), .mask_state(mask_state),
    .serv_state(serv_state), .rot_state(rot_state)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_in = '0; mask_we = 0; rot_we = 0; ack = 0; eoi_valid = 0;
    spec_mask = 0; nested = 0; auto_eoi = 0; rot_auto = 0;
    tick();
    rst = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_eoi(input logic [2:0] l);
    eoi_valid = 1'b1; eoi_line = l; tick(); eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    req_in = 8'h01; mask_we = 1; mask_wdata = 8'hF0; rot_we = 1; rot_wdata = 3'd5;
    tick();
    mask_we = 0; rot_we = 0;
    do_ack();
    do_reset();
    check("R1 req", req_state, 8'h00);
    check("R1 mask", mask_state, 8'h00);
    check("R1 serv", serv_state, 8'h00);
    check("R1 rot", rot_state, 3'd0);
    check("R1 valid", irq_valid, 1'b0);
    check("R1 trig kept", trig_level, 8'h20);
  endtask

  task automatic t_level();
    do_reset();
    req_in[5] = 1'b1; tick();
    check("R2 level set", req_state, 8'h20);
    check("R5 winner 5", {irq_valid, irq_line}, {1'b1, 3'd5});
    do_ack();
    check("R9 level ack keeps req", req_state, 8'h20);
    check("R9 level ack serv", serv_state, 8'h20);
    check("R6 equal rank blocked", irq_valid, 1'b0);
    req_in[5] = 1'b0; tick();
    check("R2 level clear", req_state, 8'h00);
    do_eoi(3'd5);
    check("R12 eoi clears", serv_state, 8'h00);
  endtask

  task automatic t_edge();
    do_reset();
    req_in[3] = 1'b1; tick();
    check("R3 edge set", req_state, 8'h08);
    req_in[3] = 1'b0; tick();
    check("R3 low keeps req", req_state, 8'h08);
    do_ack();
    check("R9 edge ack clears req", req_state, 8'h00);
    check("R9 edge ack serv", serv_state, 8'h08);
    do_eoi(3'd3);
    req_in[4] = 1'b1; tick();
    do_ack();
    tick(); tick();
    check("R3 held high no reset", req_state, 8'h00);
    check("R12 serv after ack 4", serv_state, 8'h10);
  endtask

  task automatic t_mask();
    do_reset();
    mask_we = 1; mask_wdata = 8'h02; tick(); mask_we = 0;
    check("R13 mask load", mask_state, 8'h02);
    req_in[1] = 1'b1; tick();
    check("R4 masked req kept", req_state, 8'h02);
    check("R4 masked no irq", irq_valid, 1'b0);
    mask_we = 1; mask_wdata = 8'h00; tick(); mask_we = 0;
    check("R4 unmasked irq", {irq_valid, irq_line}, {1'b1, 3'd1});
  endtask

  task automatic t_rotate();
    do_reset();
    rot_we = 1; rot_wdata = 3'd4; tick(); rot_we = 0;
    check("R13 rot load", rot_state, 3'd4);
    req_in[1] = 1'b1; req_in[6] = 1'b1; tick();
    check("R5 rotated winner", {irq_valid, irq_line}, {1'b1, 3'd6});
    rot_we = 1; rot_wdata = 3'd0; tick(); rot_we = 0;
    check("R5 unrotated winner", {irq_valid, irq_line}, {1'b1, 3'd1});
  endtask

  task automatic t_nesting();
    do_reset();
    req_in[3] = 1'b1; tick();
    do_ack();
    req_in[5] = 1'b1; tick();
    check("R6 lower blocked", irq_valid, 1'b0);
    req_in[1] = 1'b1; tick();
    check("R6 higher wins", {irq_valid, irq_line}, {1'b1, 3'd1});
  endtask

  task automatic t_special();
    do_reset();
    req_in[3] = 1'b1; tick();
    do_ack();
    req_in[5] = 1'b1; tick();
    mask_we = 1; mask_wdata = 8'h08; tick(); mask_we = 0;
    check("R7 off blocked", irq_valid, 1'b0);
    spec_mask = 1'b1; #1;
    check("R7 on passes", {irq_valid, irq_line}, {1'b1, 3'd5});
    spec_mask = 1'b0; #1;
  endtask

  task automatic t_cascade();
    do_reset();
    req_in[2] = 1'b1; tick();
    do_ack();
    req_in[2] = 1'b0; tick();
    req_in[2] = 1'b1; tick();
    check("R8 off blocked", irq_valid, 1'b0);
    nested = 1'b1; #1;
    check("R8 on passes", {irq_valid, irq_line}, {1'b1, 3'd2});
    nested = 1'b0; #1;
  endtask

  task automatic t_aeoi();
    do_reset();
    auto_eoi = 1; rot_auto = 1;
    req_in[6] = 1'b1; tick();
    do_ack();
    check("R10 serv untouched", serv_state, 8'h00);
    check("R10 rotated", rot_state, 3'd7);
    check("R10 edge req cleared", req_state, 8'h00);
    auto_eoi = 0; rot_auto = 0;
  endtask

  task automatic t_spurious();
    do_reset();
    rot_we = 1; rot_wdata = 3'd2; tick(); rot_we = 0;
    auto_eoi = 1; rot_auto = 1;
    do_ack();
    auto_eoi = 0; rot_auto = 0;
    do_ack();
    check("R11 serv", serv_state, 8'h00);
    check("R11 rot", rot_state, 3'd2);
    check("R11 req", req_state, 8'h00);
  endtask

  initial begin
    trig_level = 8'h20; eoi_line = '0; mask_wdata = '0; rot_wdata = '0;
    do_reset();
    tick();
    t_reset();
    t_level();
    t_edge();
    t_mask();
    t_rotate();
    t_nesting();
    t_special();
    t_cascade();
    t_aeoi();
    t_spurious();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule